// File: doc/BRIEF.md
# Cascadable Timer Pair Controller

The block holds two up-counting timers under a single 8-bit configuration register that software writes over a simple register bus. Each timer has its own run bit, stop bit and gate-mode bit. A pair-cascade bit turns the two counters into one double-width counter, with timer 1 as the low half. A compatibility bit can make the gate-mode bit of timer 2 govern the gating of both timers.

The register guards itself. While either timer is running, a write can change only the two run bits. The mode bits (cascade, compatibility, both stop bits and both gate-mode bits) change only while both timers are held in reset. A write that changes a mode bit and also asks for a timer to run takes the new mode but leaves both timers in reset. A separate input forces cascade off, whatever the cascade bit holds. The register and both counts are brought out as outputs, so they can always be read.

Top module: `tmr_pair_ctl`

## Requirements
- R1: After reset `cfg`, `count1` and `count2` are all zero.
- R2: Field positions in `wr_data`/`cfg`: bit 7 cascade, bit 6 compatibility, bit 5 stop timer 2, bit 4 run timer 2, bit 3 gate mode 2, bit 2 gate mode 1, bit 1 stop timer 1, bit 0 run timer 1. A write takes effect at the clock edge where `wr_en` is high.
- R3: While bit 4 or bit 0 of `cfg` is 1, a write updates only bits 4 and 0, and the other six bits keep their values.
- R4: While both run bits are 0, a write whose mode bits (7:5, 3:1) differ from the current ones stores those mode bits and leaves both run bits 0. A write with unchanged mode bits is stored in full.
- R5: A timer whose run bit is 0 has its count forced to zero. The count is zero from the second edge after its run bit falls.
- R6: A timer whose stop bit is 1 does not count, even when its run bit is 1. The other timer is not affected.
- R7: With cascade off, each enabled timer adds one per clock, starting at the first edge after the write that enables it.
- R8: A gate-mode value of 1 counts regardless of the gate input. A value of 0 counts only in cycles where that timer's gate input is high.
- R9: With the compatibility bit at 0, gate mode 2 sets the gating for both timers. With it at 1, each timer uses its own gate-mode bit.
- R10: With cascade on, timer 2 does not count on its own. It adds one on the edge where timer 1 wraps from all ones to zero.
- R11: With `cascade_off` high, the timers count independently even when the cascade bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| cascade_off | input | 1 | Forces the timers to run independently |
| gate1 | input | 1 | Gate input of timer 1 |
| gate2 | input | 1 | Gate input of timer 2 |
| cfg | output | 8 | Current configuration register |
| count1 | output | CNT_W | Timer 1 count (low half when cascaded) |
| count2 | output | CNT_W | Timer 2 count (high half when cascaded) |

## Verification
The hardest case to reach is the cascade carry. No counter can be preloaded, so timer 1 has to run through its whole range before timer 2 moves. The bench enables the cascaded pair with both gates ignored and waits exactly the length of the counter's range. It checks the counts one cycle before the wrap, on the wrap and a few cycles after it. The write-protection rules are walked through as a sequence of register writes, because what each write does depends on the run bits that the write before it left behind.

// File: rtl/tmr_pair_ctl.sv
module tmr_pair_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             cascade_off,
  input  logic             gate1,
  input  logic             gate2,
  output logic [7:0]       cfg,
  output logic [CNT_W-1:0] count1,
  output logic [CNT_W-1:0] count2
);
  localparam logic [7:0] RUN_MASK = 8'h11;

  logic locked, casc, gm1_eff, gm2_eff, en1, en2, wrap1, inc2;
  logic [7:0] cfg_nx;

  assign locked  = cfg[4] | cfg[0];
  assign cfg_nx  = locked ? ((cfg & ~RUN_MASK) | (wr_data & RUN_MASK)) :
                   ((wr_data & ~RUN_MASK) != (cfg & ~RUN_MASK)) ? (wr_data & ~RUN_MASK) :
                   wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= cfg_nx;
  end

  assign casc    = cfg[7] & ~cascade_off;
  assign gm2_eff = cfg[3];
  assign gm1_eff = cfg[6] ? cfg[2] : cfg[3];
  assign en1     = cfg[0] & ~cfg[1] & (gm1_eff | gate1);
  assign en2     = cfg[4] & ~cfg[5] & (gm2_eff | gate2);
  assign wrap1   = en1 & (&count1);
  assign inc2    = casc ? (wrap1 & cfg[4] & ~cfg[5]) : en2;

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg[0]) count1 <= '0;
    else if (en1)          count1 <= count1 + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg[4]) count2 <= '0;
    else if (inc2)         count2 <= count2 + 1'b1;
  end

  // R3: mode bits are frozen while a timer runs
  p_locked_modes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[4] | cfg[0]) |=> ((cfg & ~RUN_MASK) == $past(cfg & ~RUN_MASK)));

  // R4: a timer never starts on the same write that changes a mode
  p_no_mode_and_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg[0]) || $rose(cfg[4])) |-> ((cfg & ~RUN_MASK) == $past(cfg & ~RUN_MASK)));

  // R5: a timer held in reset shows a zero count
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[0]) |=> (count1 == '0));

  // R6: a stopped timer keeps its count
  p_stop_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1] && cfg[0]) |=> $stable(count1));

  // R10: in cascade, the high half moves only on a low-half wrap
  p_cascade_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[7] && !cascade_off && !(&count1) && cfg[4]) |=> $stable(count2));
endmodule

// File: tb/tmr_pair_ctl_bench.sv
module tmr_pair_ctl_bench;
  localparam int CNT_W = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, cascade_off = 0, gate1 = 0, gate2 = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] cfg;
  logic [CNT_W-1:0] count1, count2;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  tmr_pair_ctl #(.CNT_W(CNT_W)) u_tmr_pair_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cascade_off(cascade_off), .gate1(gate1), .gate2(gate2),
    .cfg(cfg), .count1(count1), .count2(count2));

  // {write data, expected cfg} walked from a reset register
  localparam logic [15:0] VEC [8] = '{
    16'hC4_C4, 16'h0D_0C, 16'h0D_0D, 16'hFF_1D,
    16'h00_0C, 16'h20_20, 16'h31_31, 16'hE0_20};

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    idle(2); rst_n = 1;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    check("R1 cfg", cfg, 0);
    check("R1 count1", count1, 0);
    check("R1 count2", count2, 0);
    rst_n = 1;

    // R2 R3 R4: write qualification sequence
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][15:8]);
      check($sformatf("R3/R4 vec%0d", i), cfg, VEC[i][7:0]);
    end

    // R7: independent counting, both gates ignored
    do_reset();
    wr(8'h0C); wr(8'h1D);
    check("R2 cfg", cfg, 8'h1D);
    idle(10);
    check("R7 count1", count1, 10);
    check("R7 count2", count2, 10);

    // R5: dropping the run bits clears the counts
    wr(8'h0C); idle(1);
    check("R5 count1", count1, 0);
    check("R5 count2", count2, 0);

    // R9 R8: compat 0, gate mode 2 = 0 gates both
    do_reset();
    gate1 = 0; gate2 = 1;
    wr(8'h04); wr(8'h15);
    idle(5);
    check("R9 shared gate count1", count1, 0);
    check("R8 gated count2", count2, 5);
    gate2 = 0;
    idle(3);
    check("R8 gate low count2", count2, 5);

    // R9: compat 1, own gate-mode bits
    wr(8'h04); wr(8'h44); wr(8'h55);
    check("R9 cfg", cfg, 8'h55);
    idle(5);
    check("R9 own gm1 count1", count1, 5);
    check("R9 own gm2 count2", count2, 0);

    // R6: timer 1 stopped, timer 2 runs
    do_reset();
    wr(8'h0E); wr(8'h1F);
    idle(7);
    check("R6 stopped count1", count1, 0);
    check("R6 other count2", count2, 7);
    wr(8'h1D);
    check("R3 stop locked", cfg, 8'h1F);
    idle(3);
    check("R6 still frozen", count1, 0);

    // R11: cascade forced off
    do_reset();
    cascade_off = 1;
    wr(8'h8C); wr(8'h9D);
    idle(4);
    check("R11 count1", count1, 4);
    check("R11 count2", count2, 4);
    cascade_off = 0;

    // R10: cascade carry
    do_reset();
    wr(8'h8C); wr(8'h9D);
    idle(65535);
    check("R10 pre-wrap count1", count1, 16'hFFFF);
    check("R10 pre-wrap count2", count2, 0);
    idle(1);
    check("R10 wrap count1", count1, 0);
    check("R10 wrap count2", count2, 1);
    idle(3);
    check("R10 post count1", count1, 3);
    check("R10 post count2", count2, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule